// File: doc/BRIEF.md
# Memory Readout to Shared Buffer Controller

This block copies a run of 128-bit words from external memory into a dual-port shared block RAM, so that software can read the BRAM afterwards. Software starts a copy by writing a new value into a 32-bit command register. The block tracks that register as a level. When the value differs from the one seen on the previous clock, the block makes a single start pulse, latches the start address and the word count, and goes busy.

While busy, the block sends read address requests to the memory controller over a valid/ready channel. Each accepted request brings back a burst of four words on a read-data stream. The block accepts every returned word, and each transfer on that stream is one pop from the controller's read FIFO. A word that falls inside the requested count is written into the BRAM one cycle after it is popped. The BRAM address starts at zero for each copy.

Back-pressure rules:
- The request channel holds `areq_valid` and `areq_addr` steady until `areq_ready` is seen.
- A new request goes out only if the words already owed by the FIFO, plus one more burst, still fit within the FIFO depth.
- The read-data stream is consumed whenever the block is busy: `rdat_ready` is the pop.

The `done` flag sets when the last owed word has been popped. It stays set until the next command.

Top module: `mem_readout_ctrl`

## Requirements
- R1: While reset is held and right after it is released with an unchanged command, `areq_valid`, `rdat_ready`, `bram_we` and `done` are all low.
- R2: A change in `cmd_reg` while idle starts exactly one copy. Writing the value the register already holds starts nothing.
- R3: A copy of N words issues ceil(N/4) requests. The first request address is `rd_base`, and each later one is 4 higher (addresses count 128-bit words).
- R4: Once `areq_valid` is high and `areq_ready` is low, the next cycle still has `areq_valid` high with the same `areq_addr`.
- R5: Words requested but not yet popped never exceed FIFO_DEPTH (16 by default). With a slow read stream this limit is reached but not passed.
- R6: A word popped as the k-th word of a copy (k from 0, k < N) appears on `bram_din`, with `bram_addr` = k and `bram_we` high, in the cycle after the pop.
- R7: When N is not a multiple of 4, the trailing words of the last burst are still popped, but `bram_we` stays low for them.
- R8: A word count above the BRAM depth (2^BRAM_AW) is treated as the depth. Requests and writes stop at a full BRAM.
- R9: `done` goes high on the clock edge that pops the final owed word. It stays high while `cmd_reg` is unchanged, and it is low in the cycle after a command change that starts a new copy.
- R10: A word count of zero sets `done` on the edge after the command change, and no request is issued.
- R11: A change of `cmd_reg` while a copy is in progress is ignored. The copy finishes with its original counts, and nothing restarts afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_reg | input | CMD_W | Software command register, read as a level |
| rd_base | input | MEM_AW | First memory word address of the copy |
| rd_words | input | BRAM_AW+1 | Number of 128-bit words to copy |
| areq_valid | output | 1 | Read address request valid |
| areq_ready | input | 1 | Address request FIFO can accept |
| areq_addr | output | MEM_AW | Read request address |
| rdat_valid | input | 1 | Read FIFO holds a word (not empty) |
| rdat_ready | output | 1 | Pop the read FIFO |
| rdat_data | input | DATA_W | Word at the head of the read FIFO |
| bram_addr | output | BRAM_AW | Shared BRAM write address |
| bram_din | output | DATA_W | Shared BRAM write data |
| bram_we | output | 1 | Shared BRAM write enable |
| done | output | 1 | Copy complete |

## Verification
Two functions can land on the same clock edge: a request being accepted and a word being popped. Both change the count of owed words, and each must still respect the FIFO limit. The bench provokes this by keeping the request side always ready while releasing read data only every fourth cycle. The FIFO model then fills while pops keep happening on the edges where new bursts are granted. The bench checks that its own model FIFO never holds more than the depth, that it does reach the depth, and that every popped word still lands at the right BRAM address.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_RUN  = 1'b1
  } rd_state_e;
endpackage

// File: rtl/mrc_cmd_edge.sv
module mrc_cmd_edge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic         pulse
);
  logic [W-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= level;
  end

  // one pulse per value change; a rewrite of the same value is invisible
  assign pulse = (level != seen_q);
endmodule

// File: rtl/mrc_req_gen.sv
module mrc_req_gen #(
  parameter int MEM_AW      = 32,
  parameter int CNT_W       = 11,
  parameter int BURST_WORDS = 4,
  parameter int FIFO_DEPTH  = 16,
  parameter int PEND_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MEM_AW-1:0] base,
  input  logic [CNT_W:0]    bursts,
  input  logic              pop,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [MEM_AW-1:0] req_addr
);
  localparam logic [PEND_W-1:0] ROOM   = PEND_W'(FIFO_DEPTH - BURST_WORDS);
  localparam logic [PEND_W-1:0] BSTEP  = PEND_W'(BURST_WORDS);
  localparam logic [MEM_AW-1:0] ASTEP  = MEM_AW'(BURST_WORDS);
  localparam logic [PEND_W-1:0] ONE_P  = PEND_W'(1);

  logic [CNT_W:0]    left_q;
  logic [MEM_AW-1:0] addr_q;
  logic [PEND_W-1:0] pend_q;
  logic [PEND_W-1:0] pend_add;
  logic [PEND_W-1:0] pend_sub;
  logic              fire;

  assign req_valid = (left_q != '0) && (pend_q <= ROOM);
  assign req_addr  = addr_q;
  assign fire      = req_valid && req_ready;
  assign pend_add  = fire ? BSTEP : '0;
  assign pend_sub  = pop ? ONE_P : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      addr_q <= '0;
      pend_q <= '0;
    end else if (load) begin
      left_q <= bursts;
      addr_q <= base;
      pend_q <= '0;
    end else begin
      if (fire) begin
        left_q <= left_q - 1'b1;
        addr_q <= addr_q + ASTEP;
      end
      pend_q <= pend_q + pend_add - pend_sub;
    end
  end
endmodule

// File: rtl/mrc_wr_path.sv
module mrc_wr_path #(
  parameter int DATA_W  = 128,
  parameter int BRAM_AW = 10,
  parameter int CNT_W   = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               run,
  input  logic [CNT_W-1:0]   words,
  input  logic [CNT_W:0]     total,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  output logic [BRAM_AW-1:0] bram_addr,
  output logic [DATA_W-1:0]  bram_din,
  output logic               bram_we,
  output logic               last
);
  localparam logic [CNT_W:0] ONE_I = (CNT_W+1)'(1);

  logic [CNT_W:0] idx_q;
  logic           fire;
  logic           keep;

  assign in_ready = run;
  assign fire     = in_valid && in_ready;
  assign keep     = ({1'b0, words} > idx_q);
  assign last     = fire && (idx_q == (total - ONE_I));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      bram_we   <= 1'b0;
      bram_addr <= '0;
      bram_din  <= '0;
    end else begin
      bram_we <= fire && keep;
      if (fire && keep) begin
        bram_addr <= idx_q[BRAM_AW-1:0];
        bram_din  <= in_data;
      end
      if (load)      idx_q <= '0;
      else if (fire) idx_q <= idx_q + ONE_I;
    end
  end
endmodule

// File: rtl/mem_readout_ctrl.sv
module mem_readout_ctrl
  import mrc_pkg::*;
#(
  parameter int CMD_W       = 32,
  parameter int MEM_AW      = 32,
  parameter int DATA_W      = 128,
  parameter int BRAM_AW     = 10,
  parameter int BURST_WORDS = 4,
  parameter int FIFO_DEPTH  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CMD_W-1:0]   cmd_reg,
  input  logic [MEM_AW-1:0]  rd_base,
  input  logic [BRAM_AW:0]   rd_words,
  output logic               areq_valid,
  input  logic               areq_ready,
  output logic [MEM_AW-1:0]  areq_addr,
  input  logic               rdat_valid,
  output logic               rdat_ready,
  input  logic [DATA_W-1:0]  rdat_data,
  output logic [BRAM_AW-1:0] bram_addr,
  output logic [DATA_W-1:0]  bram_din,
  output logic               bram_we,
  output logic               done
);
  localparam int CNT_W    = BRAM_AW + 1;
  localparam int BURST_LG = $clog2(BURST_WORDS);
  localparam int PEND_W   = $clog2(FIFO_DEPTH + 1) + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(1) << BRAM_AW;
  localparam logic [CNT_W:0]   ROUND_C = (CNT_W+1)'(BURST_WORDS - 1);

  rd_state_e        state_q;
  logic             start_pulse;
  logic             launch;
  logic             last_pop;
  logic             pop;
  logic [CNT_W-1:0] eff_cnt;
  logic [CNT_W:0]   bursts;
  logic [CNT_W-1:0] words_q;
  logic [CNT_W:0]   total_q;

  mrc_cmd_edge #(.W(CMD_W)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (cmd_reg),
    .pulse (start_pulse)
  );

  assign eff_cnt = (rd_words > DEPTH_C) ? DEPTH_C : rd_words;
  assign bursts  = ({1'b0, eff_cnt} + ROUND_C) >> BURST_LG;
  assign launch  = start_pulse && (state_q == RD_IDLE);
  assign pop     = rdat_valid && rdat_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      done    <= 1'b0;
      words_q <= '0;
      total_q <= '0;
    end else if (launch) begin
      words_q <= eff_cnt;
      total_q <= bursts << BURST_LG;
      if (eff_cnt == '0) begin
        done    <= 1'b1;
        state_q <= RD_IDLE;
      end else begin
        done    <= 1'b0;
        state_q <= RD_RUN;
      end
    end else if (last_pop) begin
      done    <= 1'b1;
      state_q <= RD_IDLE;
    end
  end

  mrc_req_gen #(
    .MEM_AW      (MEM_AW),
    .CNT_W       (CNT_W),
    .BURST_WORDS (BURST_WORDS),
    .FIFO_DEPTH  (FIFO_DEPTH),
    .PEND_W      (PEND_W)
  ) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (launch),
    .base      (rd_base),
    .bursts    (bursts),
    .pop       (pop),
    .req_valid (areq_valid),
    .req_ready (areq_ready),
    .req_addr  (areq_addr)
  );

  mrc_wr_path #(
    .DATA_W  (DATA_W),
    .BRAM_AW (BRAM_AW),
    .CNT_W   (CNT_W)
  ) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (launch),
    .run       (state_q == RD_RUN),
    .words     (words_q),
    .total     (total_q),
    .in_valid  (rdat_valid),
    .in_ready  (rdat_ready),
    .in_data   (rdat_data),
    .bram_addr (bram_addr),
    .bram_din  (bram_din),
    .bram_we   (bram_we),
    .last      (last_pop)
  );
endmodule

// File: rtl/mrc_readout_chk.sv
module mrc_readout_chk #(
  parameter int CMD_W       = 32,
  parameter int MEM_AW      = 32,
  parameter int BRAM_AW     = 10,
  parameter int BURST_WORDS = 4,
  parameter int FIFO_DEPTH  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CMD_W-1:0]   cmd_reg,
  input logic               areq_valid,
  input logic               areq_ready,
  input logic [MEM_AW-1:0]  areq_addr,
  input logic               rdat_valid,
  input logic               rdat_ready,
  input logic [BRAM_AW-1:0] bram_addr,
  input logic               bram_we,
  input logic               done
);
  localparam int OW = $clog2(FIFO_DEPTH + 1) + 3;

  logic [OW-1:0] owed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) owed_q <= '0;
    else owed_q <= owed_q
                 + ((areq_valid && areq_ready) ? OW'(BURST_WORDS) : '0)
                 - ((rdat_valid && rdat_ready) ? OW'(1) : '0);
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= OW'(FIFO_DEPTH));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (areq_valid && !areq_ready) |=> (areq_valid && $stable(areq_addr)));

  // R6
  write_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bram_we |-> $past(rdat_valid && rdat_ready));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bram_we && $past(bram_we)) |-> (bram_addr == $past(bram_addr) + 1'b1));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $stable(cmd_reg)) |=> done);

  // R1
  idle_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!bram_we && !done));
endmodule

bind mem_readout_ctrl mrc_readout_chk #(
  .CMD_W       (CMD_W),
  .MEM_AW      (MEM_AW),
  .BRAM_AW     (BRAM_AW),
  .BURST_WORDS (BURST_WORDS),
  .FIFO_DEPTH  (FIFO_DEPTH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_reg    (cmd_reg),
  .areq_valid (areq_valid),
  .areq_ready (areq_ready),
  .areq_addr  (areq_addr),
  .rdat_valid (rdat_valid),
  .rdat_ready (rdat_ready),
  .bram_addr  (bram_addr),
  .bram_we    (bram_we),
  .done       (done)
);

// File: tb/mem_readout_ctrl_bench.sv
module mem_readout_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BRAM_AW    = 6;
  localparam int FIFO_DEPTH = 16;
  localparam int WDOG       = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  cmd_reg = '0;
  logic [31:0]  rd_base = '0;
  logic [BRAM_AW:0] rd_words = '0;
  logic         areq_valid;
  logic         areq_ready = 1'b0;
  logic [31:0]  areq_addr;
  logic         rdat_valid = 1'b0;
  logic         rdat_ready;
  logic [127:0] rdat_data = '0;
  logic [BRAM_AW-1:0] bram_addr;
  logic [127:0] bram_din;
  logic         bram_we;
  logic         done;

  int nchk = 0, nbad = 0, cyc = 0;
  int nreq = 0, npop = 0, nwr = 0, wr_idx = 0, eff = 0, max_occ = 0;
  int req_mode = 0, dat_mode = 0;
  logic [31:0] exp_req = '0, cur_start = '0, prev_addr = '0;
  bit prev_stall = 0;
  logic [127:0] mq [0:255];
  int wp = 0, rp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_readout_ctrl #(.BRAM_AW(BRAM_AW), .FIFO_DEPTH(FIFO_DEPTH)) u_mem_readout_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_reg(cmd_reg), .rd_base(rd_base), .rd_words(rd_words),
    .areq_valid(areq_valid), .areq_ready(areq_ready), .areq_addr(areq_addr),
    .rdat_valid(rdat_valid), .rdat_ready(rdat_ready), .rdat_data(rdat_data),
    .bram_addr(bram_addr), .bram_din(bram_din), .bram_we(bram_we), .done(done)
  );

  function automatic logic [127:0] pat(input logic [31:0] a);
    return {a ^ 32'h1111_0000, ~a, a + 32'd7, a};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // memory controller and BRAM model, driven and sampled at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      nchk++; nbad++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, WDOG);
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
    areq_ready = (req_mode == 0) || (cyc % 3 == 0);
    rdat_valid = (wp != rp) && ((dat_mode == 0) || (cyc % 4 == 0));
    rdat_data  = mq[rp % 256];
    #1;
    if (rst_n) begin
      if (prev_stall)
        chk(areq_valid && areq_addr == prev_addr, "R4", "held request",
            longint'(areq_addr), longint'(prev_addr));
      prev_stall = areq_valid && !areq_ready;
      prev_addr  = areq_addr;
      if (areq_valid && areq_ready) begin
        chk(areq_addr == exp_req, "R3", "request address", longint'(areq_addr), longint'(exp_req));
        for (int i = 0; i < 4; i++) begin
          mq[wp % 256] = pat(areq_addr + 32'(i));
          wp++;
        end
        exp_req += 32'd4;
        nreq++;
      end
      if (rdat_valid && rdat_ready) begin
        rp++;
        npop++;
      end
      if (wp - rp > max_occ) max_occ = wp - rp;
      if (wp - rp > FIFO_DEPTH) chk(0, "R5", "owed words", wp - rp, FIFO_DEPTH);
      if (bram_we) begin
        chk(int'(bram_addr) == wr_idx, "R6", "bram address", longint'(bram_addr), wr_idx);
        if (bram_din !== pat(cur_start + 32'(wr_idx))) begin
          nchk++; nbad++;
          $display("FAIL R6 bram data actual=%h expected=%h", bram_din, pat(cur_start + 32'(wr_idx)));
        end else nchk++;
        chk(wr_idx < eff, "R7", "write index inside count", wr_idx, eff);
        wr_idx++;
        nwr++;
      end
    end
  end

  task automatic clear_counts();
    nreq = 0; npop = 0; nwr = 0; wr_idx = 0; max_occ = 0;
  endtask

  // call at a falling edge
  task automatic start_run(input logic [31:0] cmd, input logic [31:0] base,
                           input int cnt, input int effc);
    clear_counts();
    cur_start = base; exp_req = base; eff = effc;
    rd_base = base; rd_words = (BRAM_AW+1)'(cnt);
    cmd_reg = cmd;
  endtask

  task automatic wait_done(input string req);
    bit seen = 0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(negedge clk); #2;
      if (done) seen = 1;
    end
    chk(seen, req, "done reached", seen, 1);
  endtask

  task automatic finish_checks(input string req, input int reqs, input int writes);
    repeat (6) @(negedge clk);
    #2;
    chk(nreq == reqs, req, "request count", nreq, reqs);
    chk(npop == reqs * 4, req, "pop count", npop, reqs * 4);
    chk(nwr == writes, req, "write count", nwr, writes);
    chk(done == 1'b1, "R9", "done holds", done, 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    #2;
    chk(!areq_valid && !rdat_ready && !bram_we && !done, "R1", "outputs in reset",
        {areq_valid, rdat_ready, bram_we, done}, 0);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(!areq_valid && !rdat_ready && !bram_we && !done, "R1", "outputs after reset",
        {areq_valid, rdat_ready, bram_we, done}, 0);
  endtask

  task automatic t_basic();
    @(negedge clk);
    req_mode = 0; dat_mode = 0;
    start_run(32'h1, 32'h100, 8, 8);
    wait_done("R2");
    finish_checks("R2", 2, 8);
  endtask

  task automatic t_same_value();
    @(negedge clk);
    clear_counts();
    cmd_reg = 32'h1;
    repeat (20) @(negedge clk);
    #2;
    chk(nreq == 0 && nwr == 0, "R2", "rewrite starts nothing", nreq + nwr, 0);
    chk(done == 1'b1, "R9", "done kept on rewrite", done, 1);
  endtask

  task automatic t_done_clear();
    @(negedge clk);
    start_run(32'h2, 32'h40, 12, 12);
    @(negedge clk); #2;
    chk(done == 1'b0, "R9", "done cleared after command", done, 0);
    wait_done("R9");
    finish_checks("R9", 3, 12);
  endtask

  task automatic t_partial();
    @(negedge clk);
    start_run(32'h3, 32'h2000, 6, 6);
    wait_done("R7");
    finish_checks("R7", 2, 6);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    req_mode = 1; dat_mode = 1;
    start_run(32'h4, 32'h800, 40, 40);
    wait_done("R4");
    finish_checks("R4", 10, 40);
    req_mode = 0; dat_mode = 0;
  endtask

  task automatic t_credit();
    @(negedge clk);
    dat_mode = 1;
    start_run(32'h5, 32'h0, 32, 32);
    wait_done("R5");
    finish_checks("R5", 8, 32);
    chk(max_occ == FIFO_DEPTH, "R5", "owed words peak", max_occ, FIFO_DEPTH);
    dat_mode = 0;
  endtask

  task automatic t_zero();
    @(negedge clk);
    start_run(32'h6, 32'h500, 0, 0);
    @(negedge clk); #2;
    chk(done == 1'b1, "R10", "done on zero count", done, 1);
    repeat (10) @(negedge clk);
    #2;
    chk(nreq == 0 && npop == 0 && nwr == 0, "R10", "no traffic on zero count",
        nreq + npop + nwr, 0);
  endtask

  task automatic t_clamp();
    @(negedge clk);
    start_run(32'h7, 32'h3000, 100, 64);
    wait_done("R8");
    finish_checks("R8", 16, 64);
  endtask

  task automatic t_busy_cmd();
    @(negedge clk);
    dat_mode = 1;
    start_run(32'h8, 32'h600, 40, 40);
    repeat (10) @(negedge clk);
    cmd_reg = 32'h9;
    wait_done("R11");
    finish_checks("R11", 10, 40);
    dat_mode = 0;
    clear_counts();
    repeat (20) @(negedge clk);
    #2;
    chk(nreq == 0 && nwr == 0, "R11", "no restart after busy command", nreq + nwr, 0);
    chk(done == 1'b1, "R11", "done after busy command", done, 1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_same_value();
    t_done_clear();
    t_partial();
    t_backpressure();
    t_credit();
    t_zero();
    t_clamp();
    t_busy_cmd();
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule